// File: doc/BRIEF.md
# Polar Constituent Node Classifier

This block takes the frozen-bit mask of a length-N polar code, with N = 2^M, and gives every node of the full binary decoding tree a constituent-code label. The labels are all-frozen, all-information, repetition, single-parity-check (SPC) and a catch-all for mixed nodes. A pulse on `start_i` captures the mask. All leaves are labelled in the same cycle. After that one internal node is labelled per clock, starting at the level just above the leaves and moving toward the root, left to right within each level. A node's label comes only from the labels of its two children.

The labels live in a heap-ordered table of 2N−1 entries. The children of entry n are entries 2n+1 and 2n+2. When the walk completes, `done_o` rises and stays high. A decoder scheduler can then read the label of any node by giving its depth and its position within that level.

Top module: `polar_node_classifier`

## Requirements
- R1: After reset, `busy_o` and `done_o` are 0 and every table read returns code 0 (unlabelled).
- R2: Mask bit j describes leaf position j (depth M): a 1 (frozen) labels the leaf 1, a 0 (information) labels it 2.
- R3: An internal node whose children are (1,1) is labelled 1, and one whose children are (2,2) is labelled 2.
- R4: Children (1,2) give code 4 (length-2 repetition) only at depth M−1. At any other depth they give 3.
- R5: Children (4,2) or (5,2) give code 5 (SPC).
- R6: Children (1,4) or (1,6) give code 6 (repetition of length 4 or more).
- R7: Every child pair not named in R3 to R6 gives code 3 (mixed).
- R8: The walk covers depths M−1 down to 0, left to right within each level. `busy_o` is high from the cycle after the accepting start. `done_o` rises exactly N−1 clock edges after the edge that accepts start, and `busy_o` falls in that same cycle.
- R9: A read of depth d and position p returns the table entry at index 2^d − 1 + p. If d > M, or if p ≥ 2^d, the read returns 0.
- R10: A start that arrives while `busy_o` is high is ignored, together with the mask present at that time. `done_o` stays high until the next accepted start, and that start relabels the whole tree.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Captures mask_i and begins labelling when idle |
| mask_i | input | N | Frozen mask, bit j = leaf j, 1 = frozen |
| rd_depth_i | input | $clog2(M+1)+1 | Depth of the node to read (0 = root) |
| rd_pos_i | input | M | Position of the node within its level |
| busy_o | output | 1 | Labelling in progress |
| done_o | output | 1 | Whole tree labelled |
| rd_type_o | output | 3 | Type code of the addressed node |

## Verification
The assertions assume that `start_i` is a plain level sampled on the clock and that M is at least 2. Under those assumptions the only way back to the first internal node is an accepted start. The assertions also assume that the mask is only meaningful in the cycle a start is accepted. The stimulus holds `mask_i` and `start_i` steady across each rising edge. A start pulse is raised during a walk only together with a deliberately different mask, so that an ignored start is visible as an unchanged table.

// File: rtl/polar_cls_pkg.sv
package polar_cls_pkg;

  typedef enum logic [2:0] {
    NT_NONE = 3'd0,
    NT_ZERO = 3'd1,
    NT_ONE  = 3'd2,
    NT_MIX  = 3'd3,
    NT_REP2 = 3'd4,
    NT_SPC  = 3'd5,
    NT_REP  = 3'd6
  } node_t;

  // label of a parent from its two child labels; bottom = first level above leaves
  function automatic node_t merge_kids(input node_t l, input node_t r, input logic bottom);
    if (l == NT_ZERO && r == NT_ZERO) return NT_ZERO;
    if (l == NT_ONE && r == NT_ONE) return NT_ONE;
    if (bottom && l == NT_ZERO && r == NT_ONE) return NT_REP2;
    if ((l == NT_REP2 || l == NT_SPC) && r == NT_ONE) return NT_SPC;
    if (l == NT_ZERO && (r == NT_REP2 || r == NT_REP)) return NT_REP;
    return NT_MIX;
  endfunction

endpackage

// File: rtl/polar_walk_ctrl.sv
module polar_walk_ctrl #(
  parameter int M = 5,
  localparam int IW = M + 1,
  localparam int DW = $clog2(M + 1) + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  output logic          busy_o,
  output logic          done_o,
  output logic          load_o,
  output logic          wr_en_o,
  output logic          bottom_o,
  output logic [IW-1:0] wr_idx_o
);
  localparam int N = 1 << M;

  logic          busy_q, done_q;
  logic [DW-1:0] depth_q;
  logic [M-1:0]  pos_q;
  logic [M-1:0]  lvl_last;
  logic [IW-1:0] lvl_base;
  logic [IW-1:0] cyc_q;

  assign lvl_last = M'((1 << depth_q) - 1);
  assign lvl_base = IW'((1 << depth_q) - 1);
  assign wr_idx_o = lvl_base + IW'(pos_q);
  assign load_o   = start_i && !busy_q;
  assign wr_en_o  = busy_q;
  assign bottom_o = (depth_q == DW'(M - 1));
  assign busy_o   = busy_q;
  assign done_o   = done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
      depth_q <= '0;
      pos_q   <= '0;
      cyc_q   <= '0;
    end else if (load_o) begin
      busy_q  <= 1'b1;
      done_q  <= 1'b0;
      depth_q <= DW'(M - 1);
      pos_q   <= '0;
      cyc_q   <= '0;
    end else if (busy_q) begin
      cyc_q <= cyc_q + 1'b1;
      if (pos_q == lvl_last) begin
        pos_q <= '0;
        if (depth_q == '0) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end else begin
          depth_q <= depth_q - 1'b1;
        end
      end else begin
        pos_q <= pos_q + 1'b1;
      end
    end
  end

  AST_WALK_LEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_q) |-> (cyc_q == IW'(N - 1))); // R8

  AST_START_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && start_i) |=> !(depth_q == DW'(M - 1) && pos_q == '0)); // R10

  AST_DONE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_q && !start_i) |=> done_q); // R10

endmodule

// File: rtl/polar_type_table.sv
module polar_type_table
  import polar_cls_pkg::*;
#(
  parameter int M = 5,
  localparam int N = 1 << M,
  localparam int IW = M + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [N-1:0]  mask_i,
  input  logic          wr_en_i,
  input  logic [IW-1:0] wr_idx_i,
  input  node_t         wr_type_i,
  output node_t         kid_l_o,
  output node_t         kid_r_o,
  input  logic          rd_ok_i,
  input  logic [IW-1:0] rd_idx_i,
  output node_t         rd_type_o
);
  localparam int ENT = 2 * N - 1;

  node_t         mem [ENT];
  logic [IW-1:0] kl_idx, kr_idx;

  assign kl_idx    = {wr_idx_i[IW-2:0], 1'b1};
  assign kr_idx    = kl_idx + 1'b1;
  assign kid_l_o   = mem[kl_idx];
  assign kid_r_o   = mem[kr_idx];
  assign rd_type_o = rd_ok_i ? mem[rd_idx_i] : NT_NONE;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < ENT; i++) mem[i] <= NT_NONE;
    end else if (load_i) begin
      for (int i = 0; i < N - 1; i++) mem[i] <= NT_NONE;
      for (int j = 0; j < N; j++) mem[N - 1 + j] <= mask_i[j] ? NT_ZERO : NT_ONE;
    end else if (wr_en_i) begin
      mem[wr_idx_i] <= wr_type_i;
    end
  end

  AST_LEAF_CODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (mem[N-1] == NT_ZERO || mem[N-1] == NT_ONE)); // R2

endmodule

// File: rtl/polar_node_rule.sv
module polar_node_rule
  import polar_cls_pkg::*;
(
  input  node_t kid_l_i,
  input  node_t kid_r_i,
  input  logic  bottom_i,
  output node_t type_o
);
  assign type_o = merge_kids(kid_l_i, kid_r_i, bottom_i);
endmodule

// File: rtl/polar_node_classifier.sv
module polar_node_classifier
  import polar_cls_pkg::*;
#(
  parameter int M = 5,
  localparam int N = 1 << M,
  localparam int IW = M + 1,
  localparam int DW = $clog2(M + 1) + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [N-1:0]  mask_i,
  input  logic [DW-1:0] rd_depth_i,
  input  logic [M-1:0]  rd_pos_i,
  output logic          busy_o,
  output logic          done_o,
  output logic [2:0]    rd_type_o
);
  logic          load, wr_en, bottom, rd_ok;
  logic [IW-1:0] wr_idx, rd_idx;
  node_t         kid_l, kid_r, wr_type, rd_type;

  always_comb begin
    rd_ok  = 1'b0;
    rd_idx = '0;
    if (int'(rd_depth_i) <= M && int'(rd_pos_i) < (1 << rd_depth_i)) begin
      rd_ok  = 1'b1;
      rd_idx = IW'((1 << rd_depth_i) - 1 + int'(rd_pos_i));
    end
  end

  assign rd_type_o = rd_type;

  polar_walk_ctrl #(.M(M)) u_ctrl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (start_i),
    .busy_o   (busy_o),
    .done_o   (done_o),
    .load_o   (load),
    .wr_en_o  (wr_en),
    .bottom_o (bottom),
    .wr_idx_o (wr_idx)
  );

  polar_type_table #(.M(M)) u_table (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (load),
    .mask_i    (mask_i),
    .wr_en_i   (wr_en),
    .wr_idx_i  (wr_idx),
    .wr_type_i (wr_type),
    .kid_l_o   (kid_l),
    .kid_r_o   (kid_r),
    .rd_ok_i   (rd_ok),
    .rd_idx_i  (rd_idx),
    .rd_type_o (rd_type)
  );

  polar_node_rule u_rule (
    .kid_l_i  (kid_l),
    .kid_r_i  (kid_r),
    .bottom_i (bottom),
    .type_o   (wr_type)
  );

  AST_BUSY_DONE_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(busy_o && done_o)); // R8

  // children must already be labelled when the parent is written
  AST_KIDS_READY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en |-> (kid_l != NT_NONE && kid_r != NT_NONE)); // R8

  AST_REP2_BOTTOM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en && wr_type == NT_REP2) |-> bottom); // R4

endmodule

// File: tb/sim_polar_node_classifier.sv
module sim_polar_node_classifier;
  localparam int M   = 5;
  localparam int N   = 1 << M;
  localparam int ENT = 2 * N - 1;
  localparam int DW  = $clog2(M + 1) + 1;

  typedef struct {
    int    depth;
    int    pos;
    int    code;
    string req;
  } item_t;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start_i = 1'b0;
  logic [N-1:0]  mask_i = '0;
  logic [DW-1:0] rd_depth_i = '0;
  logic [M-1:0]  rd_pos_i = '0;
  logic          busy_o, done_o;
  logic [2:0]    rd_type_o;

  int    checks = 0;
  int    errors = 0;
  bit    mon_busy = 0;
  bit    finished = 0;
  item_t sbq[$];

  always #2 clk = ~clk;

  polar_node_classifier #(.M(M)) u0 (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .start_i    (start_i),
    .mask_i     (mask_i),
    .rd_depth_i (rd_depth_i),
    .rd_pos_i   (rd_pos_i),
    .busy_o     (busy_o),
    .done_o     (done_o),
    .rd_type_o  (rd_type_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, expv);
    end
  endtask

  task automatic push(input int d, input int p, input int c, input string r);
    item_t it;
    it.depth = d; it.pos = p; it.code = c; it.req = r;
    sbq.push_back(it);
  endtask

  task automatic drain();
    @(negedge clk);
    while (sbq.size() != 0 || mon_busy) @(negedge clk);
  endtask

  // monitor: pops expected items and compares through the read port
  initial begin
    forever begin
      @(negedge clk);
      if (sbq.size() != 0) begin
        item_t it;
        mon_busy = 1;
        it = sbq.pop_front();
        rd_depth_i = DW'(it.depth);
        rd_pos_i   = M'(it.pos);
        #1;
        chk(int'(rd_type_o) == it.code,
            $sformatf("%s d%0d p%0d", it.req, it.depth, it.pos), int'(rd_type_o), it.code);
        mon_busy = 0;
      end
    end
  end

  task automatic run_case(input logic [N-1:0] m, input bit inject);
    int e[ENT];
    int cyc;
    @(negedge clk);
    mask_i  = m;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    chk(busy_o == 1'b1 && done_o == 1'b0, "R8 busy after start", int'(busy_o), 1);
    cyc = 0;
    while (!done_o) begin
      @(negedge clk);
      cyc++;
      if (inject && cyc == 5) begin
        start_i = 1'b1;     // R10: ignored start with a different mask
        mask_i  = ~m;
      end else begin
        start_i = 1'b0;
      end
    end
    start_i = 1'b0;
    chk(cyc == N - 1, inject ? "R10 walk length with ignored start" : "R8 walk length", cyc, N - 1);
    chk(busy_o == 1'b0, "R8 busy falls with done", int'(busy_o), 0);
    // expected labels from the requirements
    for (int j = 0; j < N; j++) e[N - 1 + j] = m[j] ? 1 : 2;
    for (int n = N - 2; n >= 0; n--) begin
      int l = e[2 * n + 1];
      int r = e[2 * n + 2];
      bit bot = (n >= N / 2 - 1);
      if (l == 1 && r == 1) e[n] = 1;
      else if (l == 2 && r == 2) e[n] = 2;
      else if (bot && l == 1 && r == 2) e[n] = 4;
      else if ((l == 4 || l == 5) && r == 2) e[n] = 5;
      else if (l == 1 && (r == 4 || r == 6)) e[n] = 6;
      else e[n] = 3;  // includes (1,2) above depth M-1 (R4)
    end
    for (int n = 0; n < ENT; n++) begin
      int d = 0;
      string r;
      while ((1 << (d + 1)) - 1 <= n) d++;
      if (d == M) r = "R2";
      else if (e[n] == 1 || e[n] == 2) r = "R3";
      else if (e[n] == 4) r = "R4";
      else if (e[n] == 5) r = "R5";
      else if (e[n] == 6) r = "R6";
      else r = "R7";
      push(d, n - ((1 << d) - 1), e[n], r);
    end
    push(2, 4, 0, "R9 pos beyond level");
    push(M + 1, 0, 0, "R9 depth beyond leaves");
    drain();
    chk(done_o == 1'b1, "R10 done holds", int'(done_o), 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(busy_o == 1'b0 && done_o == 1'b0, "R1 reset flags", int'(busy_o) + int'(done_o), 0);
    rst_n = 1'b1;
    push(0, 0, 0, "R1 root");
    push(M, 0, 0, "R1 leaf");
    push(M - 1, 3, 0, "R1 inner");
    drain();
    run_case(32'hFFFF_FFFF, 1'b0);
    run_case(32'h0000_0000, 1'b0);
    run_case(32'h1713_017F, 1'b0);   // rep, spc, long rep/spc, (1,2) above bottom
    run_case(32'h8E35_C2A9, 1'b1);
    run_case(32'h0101_7F7F, 1'b0);
    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog actual 0 expected 1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule